// File: doc/BRIEF.md
# Downward-Growing LIFO Stack with Full/Empty Flags

This block is a small hardware last-in, first-out store. It holds up to eleven data words in a register array indexed 0 to 10. The bottom of the stack sits at the high end of that range, and new items go toward index 0. A pointer register always names the current top item. A push moves the pointer down by one and then writes the word at the new position. A pop takes the word under the pointer and then moves the pointer up by one.

Two flags report the fill state, and both are derived from the pointer value. The full flag is set when the pointer reaches 0. The empty flag is set when the pointer returns to 11. The current top item is visible on its own output in every cycle, and that output reads zero while the stack is empty.

Some requests cannot be carried out: a push while full, a pop while empty, or a push and a pop in the same cycle. Any of these is dropped and raises a one-cycle error pulse, and the pointer and the stored words are left as they were. A legal pop returns its word on a data output that is qualified by a one-cycle valid pulse.

Top module: `lifo_stack`

## Requirements
- R1: After reset the empty flag is 1, the full flag is 0, the error and pop-valid outputs are 0, and the top-of-stack output is zero.
- R2: Words leave in the reverse order of their arrival. After a legal push, the top-of-stack output equals the pushed word from the next cycle on, and the empty flag is 0.
- R3: The full flag is 1 exactly when 11 words are held. It rises in the cycle after the eleventh legal push, and the first legal pop clears it.
- R4: The empty flag is 1 exactly when no word is held. It rises in the cycle after the pop that removes the last word.
- R5: A push (with pop low) while full is dropped. Full stays 1, the top-of-stack word is unchanged, and the error output is 1 for exactly the next cycle.
- R6: A pop (with push low) while empty is dropped. Empty stays 1, the pop-valid output stays 0, and the error output is 1 for exactly the next cycle.
- R7: A push and a pop asserted in the same cycle are both dropped, at any fill level. The flags and the top-of-stack word are unchanged, and the error output is 1 for exactly the next cycle.
- R8: The top-of-stack output shows the most recently pushed word still held. It shows zero whenever the empty flag is 1.
- R9: A legal pop sets the pop-valid output to 1 for exactly the next cycle, with the popped word on the pop-data output. The pop-data output keeps that word until the next legal pop.
- R10: The full and empty flags are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| push_data_i | input | DATA_W | Word to push |
| pop_data_o | output | DATA_W | Word returned by the latest legal pop |
| pop_valid_o | output | 1 | One-cycle pulse after a legal pop |
| tos_o | output | DATA_W | Current top word, zero when empty |
| full_o | output | 1 | 11 words held |
| empty_o | output | 1 | No word held |
| err_o | output | 1 | One-cycle pulse after a dropped request |

## Verification
The properties place no limits on the request inputs. The three illegal request cases are separated by the levels of push and pop in the same cycle, so each property is conditioned on those levels. The properties do assume that the inputs are stable around the rising edge. The stimulus therefore changes the inputs only on the falling edge. It covers filling to the limit, draining to zero, overflow attempts, underflow attempts and simultaneous requests. It also includes a long pseudo-random mix in which push and pop are often raised together.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_BAD  = 2'd3
    } lifo_op_e;

    // Classify one cycle's request against the current fill flags.
    function automatic lifo_op_e classify(input logic push, input logic pop,
                                          input logic full, input logic empty);
        lifo_op_e op;
        if (push && pop)        op = OP_BAD;
        else if (push && full)  op = OP_BAD;
        else if (pop && empty)  op = OP_BAD;
        else if (push)          op = OP_PUSH;
        else if (pop)           op = OP_POP;
        else                    op = OP_IDLE;
        return op;
    endfunction

endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl #(
    parameter int DEPTH = 11,
    parameter int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic [PTR_W-1:0] sp_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_addr_o,
    output logic             take_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             err_o,
    output logic             rd_vld_o
);
    import lifo_pkg::*;

    localparam logic [PTR_W-1:0] SP_BOTTOM = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] SP_ONE    = PTR_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0] sp;
        logic             full;
        logic             empty;
        logic             err;
        logic             rd_vld;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    lifo_op_e    op;

    always_comb begin
        op             = classify(push_i, pop_i, st_q.full, st_q.empty);
        st_d           = st_q;
        st_d.err       = (op == OP_BAD);
        st_d.rd_vld    = (op == OP_POP);
        case (op)
            OP_PUSH: begin
                st_d.sp    = st_q.sp - SP_ONE;
                st_d.full  = (st_q.sp == SP_ONE);
                st_d.empty = 1'b0;
            end
            OP_POP: begin
                st_d.sp    = st_q.sp + SP_ONE;
                st_d.empty = ((st_q.sp + SP_ONE) == SP_BOTTOM);
                st_d.full  = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sp     <= SP_BOTTOM;
            st_q.full   <= 1'b0;
            st_q.empty  <= 1'b1;
            st_q.err    <= 1'b0;
            st_q.rd_vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sp_o      = st_q.sp;
    assign wr_en_o   = (op == OP_PUSH);
    assign wr_addr_o = st_q.sp - SP_ONE;
    assign take_o    = (op == OP_POP);
    assign full_o    = st_q.full;
    assign empty_o   = st_q.empty;
    assign err_o     = st_q.err;
    assign rd_vld_o  = st_q.rd_vld;

endmodule

// File: rtl/lifo_store.sv
module lifo_store #(
    parameter int DEPTH  = 11,
    parameter int DATA_W = 8,
    parameter int PTR_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_comb begin
            mem_d[g] = mem_q[g];
            if (wr_en_i && (wr_addr_i == PTR_W'(g)))
                mem_d[g] = wr_data_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= mem_d[g];
        end
    end

    // Address DEPTH (the bottom-of-stack pointer value) reads as zero.
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_addr_i == PTR_W'(i)) rd_data_o = mem_q[i];
        end
    end

endmodule

// File: rtl/lifo_stack.sv
module lifo_stack #(
    parameter int DEPTH  = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic [DATA_W-1:0] pop_data_o,
    output logic              pop_valid_o,
    output logic [DATA_W-1:0] tos_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              err_o
);
    localparam int PTR_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0]  sp;
    logic [PTR_W-1:0]  wr_addr;
    logic              wr_en;
    logic              take;
    logic [DATA_W-1:0] top_word;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    lifo_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .sp_o      (sp),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .take_o    (take),
        .full_o    (full_o),
        .empty_o   (empty_o),
        .err_o     (err_o),
        .rd_vld_o  (pop_valid_o)
    );

    lifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (push_data_i),
        .rd_addr_i (sp),
        .rd_data_o (top_word)
    );

    always_comb begin
        rdata_d = take ? top_word : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign pop_data_o = rdata_q;
    assign tos_o      = empty_o ? '0 : top_word;

endmodule

// File: rtl/lifo_stack_checker.sv
module lifo_stack_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_i,
    input logic              pop_i,
    input logic [DATA_W-1:0] push_data_i,
    input logic [DATA_W-1:0] pop_data_o,
    input logic              pop_valid_o,
    input logic [DATA_W-1:0] tos_o,
    input logic              full_o,
    input logic              empty_o,
    input logic              err_o
);
    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

    assert_push_lands_on_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full_o) |=> (tos_o == $past(push_data_i)) && !empty_o);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=> err_o && full_o && $stable(tos_o));

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> err_o && empty_o && !pop_valid_o);

    assert_dual_request_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> err_o && $stable(tos_o) && $stable(full_o) && $stable(empty_o));

    assert_empty_shows_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> (tos_o == '0));

    assert_pop_returns_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> pop_valid_o && (pop_data_o == $past(tos_o)));

    assert_pop_data_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_valid_o |-> $stable(pop_data_o) || $rose(rst_n));

endmodule

bind lifo_stack lifo_stack_checker #(.DATA_W(DATA_W)) u_lifo_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_data_i (push_data_i),
    .pop_data_o  (pop_data_o),
    .pop_valid_o (pop_valid_o),
    .tos_o       (tos_o),
    .full_o      (full_o),
    .empty_o     (empty_o),
    .err_o       (err_o)
);

// File: tb/tb_lifo_stack.sv
module tb_lifo_stack;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 11;
    localparam int DATA_W     = 8;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_i = 1'b0;
    logic              pop_i = 1'b0;
    logic [DATA_W-1:0] push_data_i = '0;
    logic [DATA_W-1:0] pop_data_o;
    logic              pop_valid_o;
    logic [DATA_W-1:0] tos_o;
    logic              full_o;
    logic              empty_o;
    logic              err_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model: front of the queue is the top of the stack.
    logic [DATA_W-1:0] model_q[$];
    logic [DATA_W-1:0] exp_rdata = '0;
    logic              exp_vld = 1'b0;
    logic              exp_err = 1'b0;
    string             err_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    lifo_stack #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .push_data_i (push_data_i),
        .pop_data_o  (pop_data_o),
        .pop_valid_o (pop_valid_o),
        .tos_o       (tos_o),
        .full_o      (full_o),
        .empty_o     (empty_o),
        .err_o       (err_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic p, input logic o, input logic [DATA_W-1:0] d);
        int n = model_q.size();
        exp_vld = 1'b0;
        exp_err = 1'b0;
        if (p && o)                begin exp_err = 1'b1; err_tag = "R7"; end
        else if (p && n == DEPTH)  begin exp_err = 1'b1; err_tag = "R5"; end
        else if (o && n == 0)      begin exp_err = 1'b1; err_tag = "R6"; end
        else if (p)                model_q.push_front(d);
        else if (o) begin
            exp_rdata = model_q.pop_front();
            exp_vld   = 1'b1;
        end
    endtask

    task automatic compare_all();
        int n = model_q.size();
        check("R3", "full", int'(full_o), int'(n == DEPTH));
        check("R4", "empty", int'(empty_o), int'(n == 0));
        check("R8", "tos", int'(tos_o), (n == 0) ? 0 : int'(model_q[0]));
        check(err_tag, "err", int'(err_o), int'(exp_err));
        check("R9", "pop_valid", int'(pop_valid_o), int'(exp_vld));
        check("R9", "pop_data", int'(pop_data_o), int'(exp_rdata));
        check("R10", "flags exclusive", int'(full_o && empty_o), 0);
    endtask

    task automatic cycle(input logic p, input logic o, input logic [DATA_W-1:0] d);
        push_i      = p;
        pop_i       = o;
        push_data_i = d;
        @(posedge clk);
        model_step(p, o, d);
        @(negedge clk);
        compare_all();
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "empty", int'(empty_o), 1);
        check("R1", "full", int'(full_o), 0);
        check("R1", "err", int'(err_o), 0);
        check("R1", "pop_valid", int'(pop_valid_o), 0);
        check("R1", "tos", int'(tos_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: short LIFO run
        cycle(1, 0, 8'h11);
        cycle(1, 0, 8'h22);
        cycle(1, 0, 8'h33);
        for (int i = 0; i < 3; i++) cycle(0, 1, 8'h00);
        check("R4", "empty after drain", int'(empty_o), 1);

        // R6: underflow, then idle to see the pulse drop
        cycle(0, 1, 8'h00);
        cycle(0, 0, 8'h00);
        check("R6", "err single cycle", int'(err_o), 0);

        // R7: simultaneous requests while empty
        cycle(1, 1, 8'h5A);

        // R3: fill to the limit
        for (int i = 0; i < DEPTH; i++) cycle(1, 0, 8'(8'hA0 + i));
        check("R3", "full after eleven pushes", int'(full_o), 1);

        // R5: overflow attempts, data must not land
        cycle(1, 0, 8'hEE);
        cycle(1, 0, 8'hEF);
        check("R5", "tos kept", int'(tos_o), 8'hAA);

        // R7: simultaneous requests while full
        cycle(1, 1, 8'h77);

        // R3: one pop clears full
        cycle(0, 1, 8'h00);
        check("R3", "full cleared", int'(full_o), 0);
        cycle(1, 1, 8'h66);

        // drain fully, R4
        for (int i = 0; i < DEPTH; i++) cycle(0, 1, 8'h00);
        check("R4", "empty after full drain", int'(empty_o), 1);

        // mixed pseudo-random traffic
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom_range(0, 9));
            logic p = (r < 5) || (r == 9);
            logic o = (r >= 5);
            cycle(p, o, 8'($urandom_range(0, 255)));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule